// File: doc/BRIEF.md
# Interrupt request steering router

This block sits between a bank of peripheral interrupt request lines and the three agents that can service them: a set of DMA channels, a data-transfer controller, and the CPU interrupt path. Every source is owned by exactly one of the three at any moment. A DMA channel that claims a source takes it away from the other two. An unclaimed source goes to the transfer controller when its enable bit is set, and to the CPU when the bit is clear.

Transfer-controller activations are issued one at a time. The lowest-numbered eligible source wins, and CPU masking plays no part in the choice. When the controller reports completion with either the final-transfer flag or the interrupt-select flag, the router clears that source's enable bit and latches a CPU interrupt for it. The latched interrupt stays until the CPU acknowledges it. A byte-wide register port holds the DMA channel settings and the enable bits.

Top module: `irq_steer`

## Requirements
- R1: After reset every enable bit, claim bit and select field is zero, no transfer request is outstanding, and any raised source line appears directly as a CPU request.
- R2: Register address k (k < NDMA) holds channel k: bit 7 is the claim bit and bits 3:0 select the source. dma_act[k] is high exactly when channel k's claim bit is set and its selected source line is high.
- R3: A source selected by any channel whose claim bit is set never produces a transfer-controller request and never appears as the CPU vector.
- R4: An unclaimed, raised source with its enable bit at 1 is offered to the transfer controller and not to the CPU. With the bit at 0 it is offered to the CPU and not to the controller.
- R5: When no activation is outstanding, the router issues the lowest-numbered eligible source on the next clock. It then holds xfer_req and xfer_vec unchanged until xfer_done, and issues nothing new in the meantime.
- R6: xfer_done with xfer_isel set clears the enable bit of the serviced source and latches a CPU interrupt for it.
- R7: xfer_done with xfer_last set does the same as R6 whatever the value of xfer_isel.
- R8: xfer_done with both flags clear leaves the enable bit set.
- R9: A latched CPU interrupt remains until cpu_ack is seen while that source is the presented vector, even after its line drops. cpu_vec is the lowest-numbered CPU candidate.
- R10: src_clr pulses for the serviced source in the cycle of xfer_done while an activation is outstanding. It also pulses for a claimed channel's source in the cycle of that channel's dma_done. It pulses at no other time.
- R11: Register address 8+g holds the enable bits of sources 8g to 8g+7, with bit b for source 8g+b, and it can be read and written. A completion clear in the same cycle as a write to that register wins over the written bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Level request line from each source |
| src_clr | output | NSRC | One-cycle service acknowledge back to each source |
| dma_act | output | NDMA | Activation to each DMA channel |
| dma_done | input | NDMA | Channel finished servicing its source |
| xfer_req | output | 1 | Transfer-controller activation outstanding |
| xfer_vec | output | log2(NSRC) | Source number of the outstanding activation |
| xfer_done | input | 1 | Transfer controller finished the activation |
| xfer_last | input | 1 | Transfer count reached zero |
| xfer_isel | input | 1 | Hand the source to the CPU after this transfer |
| cpu_req | output | 1 | CPU interrupt request |
| cpu_vec | output | log2(NSRC) | Source number presented to the CPU |
| cpu_ack | input | 1 | CPU acknowledges the presented vector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
The hardest case to reach is a completion clear that lands in the same cycle as a software write to the same enable register. That needs an activation outstanding on a known source, with the write strobe timed to the exact done cycle. The bench parks the controller on a source, then drives xfer_done with the interrupt-select flag and an all-ones write together, and reads the register back. A free-running phase follows with random lines, writes, completions and acknowledges. A behavioural model tracks it on every clock and catches the rarer overlaps as well, such as an acknowledge and a new hand-back in one cycle.

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int NSRC = 16,
  parameter int NDMA = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  output logic [NSRC-1:0] src_clr,
  output logic [NDMA-1:0] dma_act,
  input  logic [NDMA-1:0] dma_done,
  output logic            xfer_req,
  output logic [SELW-1:0] xfer_vec,
  input  logic            xfer_done,
  input  logic            xfer_last,
  input  logic            xfer_isel,
  output logic            cpu_req,
  output logic [SELW-1:0] cpu_vec,
  input  logic            cpu_ack,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata
);
  localparam int NGRP = (NSRC + 7) / 8;
  localparam int EN_BASE = 8;

  logic [NSRC-1:0] en, en_wr, cpu_pend, claimed, dma_clr;
  logic [NSRC-1:0] xfer_cand, cpu_cand, cur_oh, hw_clr, ack_oh;
  logic            claim [NDMA];
  logic [SELW-1:0] sel [NDMA];
  logic            busy, done_ok, has_xfer;
  logic [SELW-1:0] cur, xfer_pick;

  always_comb begin
    claimed = '0;
    dma_clr = '0;
    for (int k = 0; k < NDMA; k++) begin
      dma_act[k] = claim[k] & src_req[sel[k]];
      if (claim[k]) claimed[sel[k]] = 1'b1;
      if (claim[k] && dma_done[k]) dma_clr[sel[k]] = 1'b1;
    end
  end

  assign xfer_cand = src_req & en & ~claimed;
  assign cpu_cand  = (cpu_pend | (src_req & ~en)) & ~claimed;
  assign has_xfer  = |xfer_cand;
  assign cpu_req   = |cpu_cand;

  always_comb begin
    xfer_pick = '0;
    cpu_vec   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (xfer_cand[i]) xfer_pick = SELW'(i);
      if (cpu_cand[i])  cpu_vec   = SELW'(i);
    end
  end

  assign done_ok  = busy & xfer_done;
  assign cur_oh   = {{(NSRC-1){1'b0}}, 1'b1} << cur;
  assign hw_clr   = (done_ok && (xfer_last || xfer_isel)) ? cur_oh : '0;
  assign ack_oh   = (cpu_ack && cpu_req) ? ({{(NSRC-1){1'b0}}, 1'b1} << cpu_vec) : '0;
  assign src_clr  = dma_clr | (done_ok ? cur_oh : '0);
  assign xfer_req = busy;
  assign xfer_vec = cur;

  always_comb begin
    en_wr = en;
    for (int i = 0; i < NSRC; i++)
      if (reg_wr && int'(reg_addr) == EN_BASE + i / 8) en_wr[i] = reg_wdata[i % 8];
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NDMA; k++)
      if (int'(reg_addr) == k) begin
        reg_rdata[7]        = claim[k];
        reg_rdata[SELW-1:0] = sel[k];
      end
    for (int i = 0; i < NSRC; i++)
      if (int'(reg_addr) == EN_BASE + i / 8) reg_rdata[i % 8] = en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      cpu_pend <= '0;
      busy     <= 1'b0;
      cur      <= '0;
    end else begin
      en       <= en_wr & ~hw_clr;
      cpu_pend <= (cpu_pend & ~ack_oh) | hw_clr;
      if (!busy && has_xfer) begin
        busy <= 1'b1;
        cur  <= xfer_pick;
      end else if (done_ok) begin
        busy <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NDMA; k++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        claim[k] <= 1'b0;
        sel[k]   <= '0;
      end else if (reg_wr && int'(reg_addr) == k) begin
        claim[k] <= reg_wdata[7];
        sel[k]   <= reg_wdata[SELW-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk #(
  parameter int NSRC = 16,
  parameter int NDMA = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_clr,
  input logic [NDMA-1:0] dma_done,
  input logic            xfer_req,
  input logic [SELW-1:0] xfer_vec,
  input logic            xfer_done,
  input logic            xfer_last,
  input logic            xfer_isel,
  input logic            cpu_req,
  input logic [SELW-1:0] cpu_vec,
  input logic            cpu_ack,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] cpu_pend,
  input logic            claim [NDMA],
  input logic [SELW-1:0] sel [NDMA]
);
  logic [NSRC-1:0] owned;
  always_comb begin
    owned = '0;
    for (int k = 0; k < NDMA; k++) if (claim[k]) owned[sel[k]] = 1'b1;
  end

  AST_CPU_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !owned[cpu_vec]); // R3
  AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_vec)); // R5
  AST_ISEL_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done && xfer_isel |=> !en[$past(xfer_vec)] && cpu_pend[$past(xfer_vec)]); // R6
  AST_LAST_HANDBACK: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done && xfer_last |=> !en[$past(xfer_vec)] && cpu_pend[$past(xfer_vec)]); // R7
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ack |=> (($past(cpu_pend) & ~cpu_pend) == '0)); // R9
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_clr) |-> (xfer_req && xfer_done) || (|dma_done)); // R10
endmodule

bind irq_steer irq_steer_chk #(.NSRC(NSRC), .NDMA(NDMA)) chk_i (.*);

// File: tb/irq_steer_tb_top.sv
module irq_steer_tb_top;
  localparam int NSRC = 16;
  localparam int NDMA = 4;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_req = '0;
  logic [NDMA-1:0] dma_done = '0;
  logic xfer_done = 0, xfer_last = 0, xfer_isel = 0, cpu_ack = 0, reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [NSRC-1:0] src_clr;
  logic [NDMA-1:0] dma_act;
  logic xfer_req, cpu_req;
  logic [3:0] xfer_vec, cpu_vec;
  logic [7:0] reg_rdata;

  irq_steer #(.NSRC(NSRC), .NDMA(NDMA)) dut_i (.*);

  always #2.5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  bit m_en[NSRC], m_pend[NSRC], m_claim[NDMA];
  int m_sel[NDMA];
  bit m_busy;
  int m_cur;
  int e_dma, e_clr, e_rd, e_cvec, e_xpick;
  bit e_creq;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_comb();
    bit own[NSRC];
    foreach (own[i]) own[i] = 0;
    e_dma = 0; e_clr = 0;
    for (int k = 0; k < NDMA; k++) begin
      if (m_claim[k]) begin
        own[m_sel[k]] = 1;
        if (src_req[m_sel[k]]) e_dma |= 1 << k;
        if (dma_done[k]) e_clr |= 1 << m_sel[k];
      end
    end
    if (m_busy && xfer_done) e_clr |= 1 << m_cur;
    e_xpick = -1; e_cvec = -1;
    for (int i = 0; i < NSRC; i++) begin
      if (e_xpick < 0 && src_req[i] && m_en[i] && !own[i]) e_xpick = i;
      if (e_cvec < 0 && (m_pend[i] || (src_req[i] && !m_en[i])) && !own[i]) e_cvec = i;
    end
    e_creq = (e_cvec >= 0);
    e_rd = 0;
    if (reg_addr < NDMA) e_rd = (int'(m_claim[reg_addr]) << 7) | m_sel[reg_addr];
    else if (reg_addr >= 8 && reg_addr < 8 + NSRC / 8)
      for (int b = 0; b < 8; b++) e_rd |= int'(m_en[(reg_addr - 8) * 8 + b]) << b;
  endfunction

  task automatic compare();
    model_comb();
    chk("R2", int'(dma_act), e_dma);
    chk("R5", int'(xfer_req), int'(m_busy));
    if (m_busy) chk("R5", int'(xfer_vec), m_cur);
    chk("R9", int'(cpu_req), int'(e_creq));
    if (e_creq) chk("R9", int'(cpu_vec), e_cvec);
    chk("R10", int'(src_clr), e_clr);
    chk("R11", int'(reg_rdata), e_rd);
  endtask

  task automatic model_edge();
    bit done_ok, hand;
    int old_cur;
    model_comb();
    done_ok = m_busy && xfer_done;
    hand = done_ok && (xfer_last || xfer_isel);
    old_cur = m_cur;
    if (cpu_ack && e_creq) m_pend[e_cvec] = 0;
    if (reg_wr) begin
      if (reg_addr < NDMA) begin
        m_claim[reg_addr] = reg_wdata[7];
        m_sel[reg_addr] = int'(reg_wdata[3:0]);
      end else if (reg_addr >= 8 && reg_addr < 8 + NSRC / 8)
        for (int b = 0; b < 8; b++) m_en[(reg_addr - 8) * 8 + b] = reg_wdata[b];
    end
    if (hand) begin m_en[old_cur] = 0; m_pend[old_cur] = 1; end
    if (!m_busy && e_xpick >= 0) begin m_busy = 1; m_cur = e_xpick; end
    else if (done_ok) m_busy = 0;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    cyc();
    reg_wr = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    reg_addr = 4'(a);
    #1 chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (m_en[i]) begin m_en[i] = 0; m_pend[i] = 0; end
    foreach (m_claim[k]) begin m_claim[k] = 0; m_sel[k] = 0; end
    m_busy = 0; m_cur = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R1", int'(xfer_req), 0);
    chk("R1", int'(cpu_req), 0);
    rd("R1", 0, 0);
    rd("R1", 8, 0);
    @(negedge clk);
    src_req[5] = 1;
    #1 chk("R1", int'(cpu_req), 1);
    chk("R1", int'(cpu_vec), 5);
    idle(2);

    wr(8, 8'h20);
    idle(2);
    chk("R4", int'(xfer_req), 1);
    chk("R4", int'(xfer_vec), 5);
    chk("R4", int'(cpu_req), 0);

    src_req[3] = 1; src_req[9] = 1;
    wr(8, 8'h28); wr(9, 8'h02);
    idle(2);
    chk("R5", int'(xfer_vec), 5);
    xfer_done = 1;
    #1 chk("R10", int'(src_clr), 32'h20);
    cyc();
    xfer_done = 0; src_req[5] = 0;
    rd("R8", 8, 8'h28);
    idle(2);
    chk("R5", int'(xfer_vec), 3);

    xfer_done = 1; xfer_isel = 1;
    cyc();
    xfer_done = 0; xfer_isel = 0;
    rd("R6", 8, 8'h20);
    #1 chk("R6", int'(cpu_vec), 3);
    src_req[3] = 0;
    idle(3);
    chk("R9", int'(cpu_req), 1);
    chk("R9", int'(cpu_vec), 3);
    cpu_ack = 1;
    cyc();
    cpu_ack = 0;
    #1 chk("R9", int'(cpu_req), 0);

    idle(1);
    chk("R7", int'(xfer_vec), 9);
    xfer_done = 1; xfer_last = 1;
    cyc();
    xfer_done = 0; xfer_last = 0;
    rd("R7", 9, 0);
    src_req[9] = 0;
    cpu_ack = 1; cyc(); cpu_ack = 0;

    wr(8, 8'h80);
    wr(1, 8'h87);
    src_req[7] = 1;
    idle(2);
    chk("R2", int'(dma_act), 2);
    chk("R3", int'(xfer_req), 0);
    chk("R3", int'(cpu_req), 0);
    dma_done[1] = 1;
    #1 chk("R10", int'(src_clr), 32'h80);
    cyc();
    dma_done = '0; src_req[7] = 0;
    wr(1, 0);

    wr(8, 8'h04);
    src_req[2] = 1;
    idle(2);
    chk("R11", int'(xfer_vec), 2);
    xfer_done = 1; xfer_isel = 1;
    wr(8, 8'hFF);
    xfer_done = 0; xfer_isel = 0;
    rd("R11", 8, 8'hFB);
    src_req[2] = 0;
    wr(8, 0); wr(9, 0);
    cpu_ack = 1; idle(2); cpu_ack = 0;

    for (int n = 0; n < 600; n++) begin
      src_req   = NSRC'($urandom & $urandom);
      dma_done  = NDMA'($urandom & $urandom);
      xfer_done = ($urandom % 4) == 0;
      xfer_last = ($urandom % 3) == 0;
      xfer_isel = ($urandom % 3) == 0;
      cpu_ack   = ($urandom % 4) == 0;
      reg_wr    = ($urandom % 6) == 0;
      reg_addr  = 4'($urandom);
      reg_wdata = 8'($urandom);
      cyc();
    end
    reg_wr = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule